// File: doc/BRIEF.md
# Sleep-Entry Processor Stop Sequencer

This block puts the two processors of a dual-socket platform into a clock-stopped condition when the platform heads for sleep. A one-cycle sleep request carries a two-bit target code. On that request the block pulls a single shared active-low stop-clock line low, which reaches both processors at once. It then watches a one-cycle acknowledge pulse that arrives each time a processor grants the stop. The first acknowledge starts a fixed wait of `MIN_WAIT` bus clocks, which gives the second processor time to answer. When the wait ends, the block pulls the active-low processor sleep line low and raises `done`.

The processor sleep line is gated. For the light sleep target it is driven only when `slp_en` is 1. With `slp_en` at 0, the block parks with stop-clock asserted and reports `done` on the first acknowledge. Every deeper target runs the same light-sleep path and always drives the processor sleep line before `done`, because power is removed from the processors afterwards anyway.

A wake request releases the processor sleep line first and the stop-clock line one clock later, then returns the block to idle. A saturating count of acknowledges is exposed for observation.

States:
- `ST_IDLE`: nothing asserted.
- `ST_STOP`: stop-clock asserted, waiting for the first acknowledge.
- `ST_WAIT`: counting the minimum delay.
- `ST_SLEEP`: both lines asserted, `done` high.
- `ST_PARK`: stop-clock only, `done` high.
- `ST_WAKE`: processor sleep released, stop-clock still low.

Transitions:
- `ST_IDLE` goes to `ST_STOP` on a request.
- `ST_STOP` goes to `ST_WAIT` on an acknowledge when sleep is wanted, and to `ST_PARK` on an acknowledge when it is not.
- `ST_WAIT` goes to `ST_SLEEP` when the wait expires.
- `ST_STOP`, `ST_WAIT`, `ST_SLEEP` and `ST_PARK` go to `ST_WAKE` on a wake request. Wake has priority over an acknowledge.
- `ST_WAKE` goes to `ST_IDLE` unconditionally.

Top module: `sleep_stop_seq`

## Requirements
- R1: On synchronous active-high reset, `stpclk_n`=1, `cpuslp_n`=1, `done`=0 and `grant_cnt`=0.
- R2: A `sleep_req` sampled in idle drives `stpclk_n` low after that same clock edge, with `cpuslp_n`=1 and `done`=0. Both stay that way until the first acknowledge.
- R3: When processor sleep is wanted, `cpuslp_n` falls exactly `MIN_WAIT` (default 60) clock edges after the edge that samples the first `stop_grant` pulse.
- R4: Further `stop_grant` pulses during the wait do not restart it.
- R5: For target code 0 (light sleep) with `slp_en`=0, `done` rises one edge after the first acknowledge and `cpuslp_n` stays high.
- R6: For target codes 1, 2 and 3 (deeper states), `cpuslp_n` is driven low after the wait whatever the value of `slp_en`.
- R7: When sleep is wanted, `done` rises on the same edge as `cpuslp_n` falls. `done` is never high while `stpclk_n` is high.
- R8: A `wake_req` while `done`=1 raises `cpuslp_n` and clears `done` after one edge, then raises `stpclk_n` one edge later.
- R9: A `wake_req` before `done` (waiting for an acknowledge, or during the wait) aborts the sequence with the same release order. `cpuslp_n` is never driven low afterwards.
- R10: `grant_cnt` counts `stop_grant` pulses while stop-clock is asserted and saturates at 2. It is cleared by an accepted request. Pulses in idle leave it unchanged.
- R11: `sleep_req` is ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | One-cycle sleep request |
| state_code | input | 2 | Target: 0 light, 1–3 deeper |
| stop_grant | input | 1 | One-cycle acknowledge pulse |
| slp_en | input | 1 | Allows the processor sleep line for the light target |
| wake_req | input | 1 | One-cycle wake request |
| stpclk_n | output | 1 | Stop-clock to both processors, active low |
| cpuslp_n | output | 1 | Processor sleep, active low |
| done | output | 1 | Sleep condition reached |
| grant_cnt | output | 2 | Saturating acknowledge count |

## Verification
The checker assumes `stop_grant`, `sleep_req` and `wake_req` are single-cycle pulses. It also assumes the minimum-wait window is measured from the first acknowledge seen while stop-clock is low. The stimulus drives every pulse for exactly one clock, away from the clock edge. The second acknowledge is placed at random inside the wait window, and extra requests are dropped into busy states on purpose. Wake requests are issued only after a sequence is done, or at chosen points before it, so each release order falls within what the checker models.

// File: rtl/sss_pkg.sv
package sss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_WAIT,
        ST_SLEEP,
        ST_PARK,
        ST_WAKE
    } sss_state_e;

    localparam logic [1:0] CODE_LIGHT = 2'd0;
endpackage

// File: rtl/sss_wait_timer.sv
module sss_wait_timer #(
    parameter int MIN_WAIT = 60,
    localparam int CW = $clog2(MIN_WAIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam logic [CW-1:0] LAST = CW'(MIN_WAIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/sss_grant_tally.sv
module sss_grant_tally #(
    parameter int GRANT_MAX = 2,
    localparam int GW = $clog2(GRANT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          enable,
    input  logic          pulse,
    output logic [GW-1:0] count
);
    localparam logic [GW-1:0] TOP = GW'(GRANT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (enable && pulse && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sss_fsm.sv
module sss_fsm
    import sss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic [1:0] state_code,
    input  logic       stop_grant,
    input  logic       slp_en,
    input  logic       wake_req,
    input  logic       expired,
    output sss_state_e state,
    output logic       timer_clear,
    output logic       timer_run,
    output logic       tally_clear,
    output logic       tally_enable,
    output logic       stpclk_n,
    output logic       cpuslp_n,
    output logic       done
);
    sss_state_e next;
    logic       deep_q;
    logic       use_sleep;

    assign use_sleep = slp_en || deep_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            deep_q <= 1'b0;
        end else begin
            state <= next;
            if (state == ST_IDLE && sleep_req) begin
                deep_q <= (state_code != CODE_LIGHT);
            end
        end
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE: begin
                if (sleep_req) next = ST_STOP;
            end
            ST_STOP: begin
                if (wake_req)        next = ST_WAKE;
                else if (stop_grant) next = use_sleep ? ST_WAIT : ST_PARK;
            end
            ST_WAIT: begin
                if (wake_req)     next = ST_WAKE;
                else if (expired) next = ST_SLEEP;
            end
            ST_SLEEP, ST_PARK: begin
                if (wake_req) next = ST_WAKE;
            end
            ST_WAKE: next = ST_IDLE;
            default: next = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        stpclk_n     = (state == ST_IDLE);
        cpuslp_n     = (state != ST_SLEEP);
        done         = (state == ST_SLEEP) || (state == ST_PARK);
        timer_clear  = (state == ST_STOP) && stop_grant && !wake_req;
        timer_run    = (state == ST_WAIT);
        tally_clear  = (state == ST_IDLE) && sleep_req;
        tally_enable = (state != ST_IDLE);
    end
endmodule

// File: rtl/sleep_stop_seq.sv
module sleep_stop_seq #(
    parameter int MIN_WAIT  = 60,
    parameter int GRANT_MAX = 2,
    localparam int GW = $clog2(GRANT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_req,
    input  logic [1:0]    state_code,
    input  logic          stop_grant,
    input  logic          slp_en,
    input  logic          wake_req,
    output logic          stpclk_n,
    output logic          cpuslp_n,
    output logic          done,
    output logic [GW-1:0] grant_cnt
);
    import sss_pkg::*;

    sss_state_e fsm_state;
    logic       expired;
    logic       timer_clear;
    logic       timer_run;
    logic       tally_clear;
    logic       tally_enable;

    sss_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sleep_req    (sleep_req),
        .state_code   (state_code),
        .stop_grant   (stop_grant),
        .slp_en       (slp_en),
        .wake_req     (wake_req),
        .expired      (expired),
        .state        (fsm_state),
        .timer_clear  (timer_clear),
        .timer_run    (timer_run),
        .tally_clear  (tally_clear),
        .tally_enable (tally_enable),
        .stpclk_n     (stpclk_n),
        .cpuslp_n     (cpuslp_n),
        .done         (done)
    );

    sss_wait_timer #(.MIN_WAIT(MIN_WAIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (timer_clear),
        .run     (timer_run),
        .expired (expired)
    );

    sss_grant_tally #(.GRANT_MAX(GRANT_MAX)) u_tally (
        .clk    (clk),
        .rst    (rst),
        .clear  (tally_clear),
        .enable (tally_enable),
        .pulse  (stop_grant),
        .count  (grant_cnt)
    );
endmodule

// File: rtl/sss_checker.sv
module sss_checker
    import sss_pkg::*;
#(
    parameter int MIN_WAIT  = 60,
    parameter int GRANT_MAX = 2,
    localparam int GW = $clog2(GRANT_MAX + 1),
    localparam int CW = $clog2(MIN_WAIT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          sleep_req,
    input logic          stop_grant,
    input logic          stpclk_n,
    input logic          cpuslp_n,
    input logic          done,
    input logic [GW-1:0] grant_cnt,
    input sss_state_e    fsm_state
);
    logic          seen_q;
    logic [CW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst || stpclk_n) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (!seen_q) begin
            if (stop_grant) begin
                seen_q  <= 1'b1;
                since_q <= '0;
            end
        end else if (since_q != CW'(MIN_WAIT)) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R2
    req_to_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_IDLE && sleep_req) |=> !stpclk_n);

    // R3
    min_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpuslp_n) |-> (seen_q && since_q == CW'(MIN_WAIT)));

    // R7
    done_under_stop_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !stpclk_n);

    // R7
    sleep_under_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !cpuslp_n |-> (!stpclk_n && done));

    // R8
    release_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stpclk_n) |-> (cpuslp_n && $past(cpuslp_n)));

    // R8
    sleep_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpuslp_n) |-> !stpclk_n);

    // R10
    tally_limit_chk: assert property (@(posedge clk) disable iff (rst)
        grant_cnt <= GW'(GRANT_MAX));
endmodule

bind sleep_stop_seq sss_checker #(.MIN_WAIT(MIN_WAIT), .GRANT_MAX(GRANT_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .stop_grant (stop_grant),
    .stpclk_n   (stpclk_n),
    .cpuslp_n   (cpuslp_n),
    .done       (done),
    .grant_cnt  (grant_cnt),
    .fsm_state  (fsm_state)
);

// File: tb/sleep_stop_seq_tb.sv
module sleep_stop_seq_tb;
    localparam int MIN_WAIT = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic [1:0] state_code = 2'd0;
    logic       stop_grant = 1'b0;
    logic       slp_en = 1'b0;
    logic       wake_req = 1'b0;
    logic       stpclk_n;
    logic       cpuslp_n;
    logic       done;
    logic [1:0] grant_cnt;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    sleep_stop_seq #(.MIN_WAIT(MIN_WAIT), .GRANT_MAX(2)) u_dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .state_code(state_code),
        .stop_grant(stop_grant), .slp_en(slp_en), .wake_req(wake_req),
        .stpclk_n(stpclk_n), .cpuslp_n(cpuslp_n), .done(done), .grant_cnt(grant_cnt)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic bit want_sleep(logic [1:0] code, bit en);
        return en || (code != 2'd0);
    endfunction

    function automatic int sat2(int n);
        return (n > 2) ? 2 : n;
    endfunction

    task automatic request(logic [1:0] code);
        sleep_req  = 1'b1;
        state_code = code;
        step();
        sleep_req  = 1'b0;
        chk("R2 stpclk_n", stpclk_n, 0);
        chk("R2 cpuslp_n", cpuslp_n, 1);
        chk("R2 done", done, 0);
        chk("R10 cleared", grant_cnt, 0);
    endtask

    task automatic wake_release();
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        chk("R8 cpuslp_n released", cpuslp_n, 1);
        chk("R8 stpclk_n held", stpclk_n, 0);
        chk("R8 done cleared", done, 0);
        step();
        chk("R8 stpclk_n released", stpclk_n, 1);
    endtask

    // full sequence; g2 = step of second grant (0 none), extra = step of ignored request
    task automatic run_seq(logic [1:0] code, bit en, int d1, int g2, int extra);
        bit want;
        int grants;
        want   = want_sleep(code, en);
        slp_en = en;
        request(code);
        for (int i = 0; i < d1; i++) begin
            step();
            chk("R2 waiting for grant", stpclk_n + 2 * done, 0);
        end
        stop_grant = 1'b1;
        step();
        stop_grant = 1'b0;
        grants = 1;
        if (want) chk("R3 done before wait", done, 0);
        else begin
            chk("R5 done after grant", done, 1);
            chk("R5 cpuslp_n", cpuslp_n, 1);
        end
        for (int k = 1; k <= MIN_WAIT; k++) begin
            stop_grant = (k == g2);
            sleep_req  = (k == extra);
            state_code = 2'd0;
            step();
            if (k == g2) grants++;
            if (want && k == MIN_WAIT - 1) chk("R3/R4 early", cpuslp_n, 1);
            if (want && k == MIN_WAIT) begin
                chk(code != 0 && !en ? "R6 cpuslp_n" : "R3 cpuslp_n", cpuslp_n, 0);
                chk("R7 done", done, 1);
            end
            if (!want && k == MIN_WAIT) chk("R5 cpuslp_n held", cpuslp_n, 1);
        end
        stop_grant = 1'b0;
        sleep_req  = 1'b0;
        chk("R10/R11 grant_cnt", grant_cnt, sat2(grants));
        chk("R11 stpclk_n", stpclk_n, 0);
        wake_release();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step();
        step();
        chk("R1 stpclk_n", stpclk_n, 1);
        chk("R1 cpuslp_n", cpuslp_n, 1);
        chk("R1 done", done, 0);
        chk("R1 grant_cnt", grant_cnt, 0);
        rst = 1'b0;
        step();

        // directed corners
        run_seq(2'd0, 1'b1, 0, 30, 10);
        run_seq(2'd0, 1'b0, 2, 5, 0);
        run_seq(2'd1, 1'b0, 1, 59, 0);
        run_seq(2'd2, 1'b0, 3, 0, 40);
        run_seq(2'd3, 1'b0, 0, 1, 0);

        // grants in idle ignored
        stop_grant = 1'b1;
        step();
        stop_grant = 1'b0;
        chk("R10 idle grant cnt", grant_cnt, 2);
        chk("R10 idle stpclk_n", stpclk_n, 1);

        // saturation in park
        slp_en = 1'b0;
        request(2'd0);
        for (int i = 0; i < 3; i++) begin
            stop_grant = 1'b1;
            step();
        end
        stop_grant = 1'b0;
        chk("R10 saturate", grant_cnt, 2);
        wake_release();

        // abort during wait
        slp_en = 1'b1;
        request(2'd0);
        stop_grant = 1'b1;
        step();
        stop_grant = 1'b0;
        repeat (20) step();
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        chk("R9 cpuslp_n", cpuslp_n, 1);
        chk("R9 stpclk_n held", stpclk_n, 0);
        step();
        chk("R9 stpclk_n released", stpclk_n, 1);
        repeat (MIN_WAIT + 5) step();
        chk("R9 no late sleep", cpuslp_n, 1);

        // abort before grant, wake beats a simultaneous grant
        request(2'd2);
        step();
        wake_req   = 1'b1;
        stop_grant = 1'b1;
        step();
        wake_req   = 1'b0;
        stop_grant = 1'b0;
        chk("R9 early done", done, 0);
        chk("R9 early stpclk_n", stpclk_n, 0);
        step();
        chk("R9 early release", stpclk_n, 1);
        repeat (MIN_WAIT + 5) step();
        chk("R9 early no sleep", cpuslp_n, 1);

        // random sequences
        for (int n = 0; n < 16; n++) begin
            logic [1:0] code;
            bit en;
            int d1, g2, ex;
            code = 2'($urandom_range(0, 3));
            en   = 1'($urandom_range(0, 1));
            d1   = $urandom_range(0, 6);
            g2   = $urandom_range(0, MIN_WAIT - 5);
            ex   = $urandom_range(0, MIN_WAIT - 1);
            run_seq(code, en, d1, g2, ex);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule